// File: doc/BRIEF.md
# TDM Frame Transmitter

This block turns parallel audio samples into a serial bit stream laid out as a time-division-multiplexed frame. Each frame holds a programmable number of slots, and each slot holds a programmable number of bits. A sample of narrower width sits inside its slot, either packed against the slot's first bit or against its last bit. The block advances one bit position on every cycle where the bit-clock enable is high. The bit clock itself and the sample store that feeds the block live elsewhere.

A frame-sync line marks where each frame starts, and its shape is set by independent fields. The pulse is either one bit long or one slot long. It either lands on the first data bit or leads it by one bit. Its active level is either high or low. The common serial audio framings come from combinations of these fields: I2S is slot-long, early and active-low; left-justified is slot-long, aligned and active-high; DSP-A is bit-long and early; DSP-B is bit-long and aligned. A per-slot enable mask chooses which slots carry samples. In slave mode the block does not drive frame sync. It re-aligns its frame counter to an incoming sync edge instead. A one-slot frame gives the plain single-channel mode, and more slots give network mode.

Samples arrive over a valid/ready handshake, one per enabled slot. When an enabled slot begins and no sample is offered, the block flags underrun and sends zeros for that slot. Two more status outputs mark the final slot of the frame and enabled slots with an even index.

Top module: `tdm_frame_tx`

## Requirements
- R1: Bit position changes only on cycles with `bclk_en` high. The first such cycle after reset starts slot 0 at bit 0. A frame is `cfg_slots` slots of `cfg_slot_w` bits each, and `cfg_slots` = 1 gives a one-slot frame.
- R2: While `rst_n` is low, `sdo` is 0, `fs_out` equals `cfg_fs_inv`, and `in_ready`, `underrun`, `last_slot` and `even_slot` are 0. These values hold until the first `bclk_en` cycle.
- R3: With `cfg_fs_word` = 1 the frame-sync pulse lasts `cfg_slot_w` bits. With `cfg_fs_word` = 0 it lasts one bit.
- R4: With `cfg_fs_early` = 0 the pulse starts on bit 0 of slot 0. With `cfg_fs_early` = 1 it starts on the final bit of the previous frame.
- R5: `fs_out` is high while the pulse is active when `cfg_fs_inv` = 0, and low while it is active when `cfg_fs_inv` = 1. The pulse shape does not affect this.
- R6: Data is sent MSB first. With `cfg_right_align` = 0, sample bits `cfg_word_w`-1 down to 0 fill the first `cfg_word_w` bits of the slot and zeros follow. With `cfg_right_align` = 1, zeros come first and the sample fills the last `cfg_word_w` bits. Bits of `in_data` at or above `cfg_word_w` are ignored.
- R7: `in_ready` is high only in a `bclk_en` cycle that begins slot s with `cfg_slot_mask[s]` = 1. A sample is taken when `in_valid` and `in_ready` are both high. A slot whose mask bit is 0 takes no sample and sends only zeros.
- R8: If an enabled slot begins with `in_valid` low, `underrun` is high for the whole of that slot and the slot sends only zeros.
- R9: `last_slot` is high during slot `cfg_slots`-1. `even_slot` is high during an enabled slot with an even index, counting from slot 0.
- R10: With `cfg_slave` = 1, `fs_out` stays at its inactive level. When `fs_in` XOR `cfg_fs_inv` rises between two `bclk_en` cycles, the bit that begins becomes slot 0 bit 0 if `cfg_fs_early` = 0, or the final bit of the frame if `cfg_fs_early` = 1. In the second case that bit sends zero.
- R11: `sdo`, `fs_out` and the status outputs do not change on cycles where `bclk_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bclk_en | input | 1 | One-cycle strobe per serial bit period |
| cfg_slots | input | 4 | Slots per frame, 1 to MAX_SLOTS |
| cfg_slot_w | input | 6 | Bits per slot |
| cfg_word_w | input | 5 | Sample width, not above the slot width |
| cfg_slot_mask | input | 8 | Per-slot enable, bit s for slot s |
| cfg_fs_word | input | 1 | 1: sync lasts one slot, 0: one bit |
| cfg_fs_early | input | 1 | 1: sync leads the frame by one bit |
| cfg_fs_inv | input | 1 | 1: sync active low |
| cfg_right_align | input | 1 | 1: sample packed at the end of the slot |
| cfg_slave | input | 1 | 1: follow external sync on fs_in |
| fs_in | input | 1 | External frame sync in slave mode |
| in_data | input | 24 | Parallel sample |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample taken this cycle when valid |
| sdo | output | 1 | Serial data |
| fs_out | output | 1 | Generated frame sync |
| underrun | output | 1 | Current enabled slot had no sample |
| last_slot | output | 1 | Current slot is the last of the frame |
| even_slot | output | 1 | Current slot is enabled and even-indexed |

## Verification
Two pairs of events can fall in the same cycle. An underrun can land in the final slot of a frame, so `underrun` and `last_slot` rise on the same bit. In slave mode, a sync edge can arrive on the very bit where the free-running counter was about to load a slot. The first case is forced by withholding the sample meant for the final slot of a three-slot frame. The second is forced by driving an external sync that is offset from the block's own count. In both cases the bench checks every bit period against a frame model it keeps itself. That model tracks position, sample consumption and sync shape, so each output is compared on the same bit where the two events meet.

// File: rtl/tdm_frame_pkg.sv
// Shared helpers for the TDM frame transmitter.
// Assumes frame indices are small non-negative integers.
package tdm_frame_pkg;

    // Decide whether frame-sync is active at bit index fidx of a frame flen long.
    function automatic logic fs_window(input int fidx, input int flen,
                                       input int fs_len, input logic early);
        int rel;
        if (flen <= 0) return 1'b0;
        if (early) rel = (fidx == flen - 1) ? 0 : fidx + 1;
        else       rel = fidx;
        return (rel < fs_len);
    endfunction

endpackage

// File: rtl/tdm_frame_timer.sv
// Frame position counter and frame-sync generator.
// Holds the slot and bit index of the bit currently on the line. It moves
// one bit per bclk_en cycle and re-aligns to an external sync edge in slave
// mode. Assumes cfg_slots >= 1, cfg_slot_w >= 1 and config stable outside reset.
module tdm_frame_timer #(
    parameter int MAX_SLOTS = 8,
    parameter int SLOT_MAX  = 32,
    localparam int SIW = $clog2(MAX_SLOTS),
    localparam int CNW = $clog2(MAX_SLOTS + 1),
    localparam int BIW = $clog2(SLOT_MAX),
    localparam int SWW = $clog2(SLOT_MAX + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bclk_en,
    input  logic [CNW-1:0] cfg_slots,
    input  logic [SWW-1:0] cfg_slot_w,
    input  logic           cfg_fs_word,
    input  logic           cfg_fs_early,
    input  logic           cfg_fs_inv,
    input  logic           cfg_slave,
    input  logic           fs_in,
    output logic           started,
    output logic [SIW-1:0] slot_cnt,
    output logic [BIW-1:0] bit_cnt,
    output logic [SIW-1:0] next_slot,
    output logic           slot_start,
    output logic           resync,
    output logic           fs_out
);
    import tdm_frame_pkg::*;

    logic           started_q, act_prev_q;
    logic [SIW-1:0] slot_q, nxt_slot;
    logic [BIW-1:0] bit_q, nxt_bit;
    logic           act_now, last_bit, last_pos_slot;
    int             fidx, flen, fslen;

    assign act_now       = fs_in ^ cfg_fs_inv;
    assign resync        = cfg_slave && act_now && !act_prev_q;
    assign last_bit      = int'(bit_q) == int'(cfg_slot_w) - 1;
    assign last_pos_slot = int'(slot_q) == int'(cfg_slots) - 1;

    // Work out the position of the bit that starts on the next tick.
    always_comb begin
        nxt_slot = slot_q;
        nxt_bit  = bit_q + 1'b1;
        if (resync) begin
            if (cfg_fs_early) begin
                nxt_slot = SIW'(int'(cfg_slots) - 1);
                nxt_bit  = BIW'(int'(cfg_slot_w) - 1);
            end else begin
                nxt_slot = '0;
                nxt_bit  = '0;
            end
        end else if (!started_q) begin
            nxt_slot = '0;
            nxt_bit  = '0;
        end else if (last_bit) begin
            nxt_bit  = '0;
            nxt_slot = last_pos_slot ? '0 : slot_q + 1'b1;
        end
    end

    // Register the position and the previous sampled sync level on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started_q  <= 1'b0;
            act_prev_q <= 1'b0;
            slot_q     <= '0;
            bit_q      <= '0;
        end else if (bclk_en) begin
            started_q  <= 1'b1;
            act_prev_q <= act_now;
            slot_q     <= nxt_slot;
            bit_q      <= nxt_bit;
        end
    end

    // Frame index, frame length and sync length for the sync window.
    always_comb begin
        fidx  = int'(slot_q) * int'(cfg_slot_w) + int'(bit_q);
        flen  = int'(cfg_slots) * int'(cfg_slot_w);
        fslen = cfg_fs_word ? int'(cfg_slot_w) : 1;
    end

    assign fs_out     = (started_q && !cfg_slave && fs_window(fidx, flen, fslen, cfg_fs_early))
                        ^ cfg_fs_inv;
    assign started    = started_q;
    assign slot_cnt   = slot_q;
    assign bit_cnt    = bit_q;
    assign next_slot  = nxt_slot;
    assign slot_start = (nxt_bit == '0);

    // R11
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bclk_en |=> ($stable(bit_q) && $stable(slot_q)));

    // R1
    bit_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && bclk_en && !resync && last_bit) |=> (bit_q == '0));

endmodule

// File: rtl/tdm_slot_serializer.sv
// Holds the sample for the current slot and picks the bit for the line.
// The slot is sent MSB first, with the sample packed at the start or at the
// end of the slot and zeros elsewhere. Assumes cfg_word_w <= cfg_slot_w.
module tdm_slot_serializer #(
    parameter int SLOT_MAX = 32,
    parameter int WORD_MAX = 24,
    localparam int BIW = $clog2(SLOT_MAX),
    localparam int SWW = $clog2(SLOT_MAX + 1),
    localparam int WIW = $clog2(WORD_MAX),
    localparam int WWW = $clog2(WORD_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reload,
    input  logic                take,
    input  logic [WORD_MAX-1:0] in_data,
    input  logic [WWW-1:0]      cfg_word_w,
    input  logic [SWW-1:0]      cfg_slot_w,
    input  logic                cfg_right,
    input  logic [BIW-1:0]      bit_cnt,
    output logic                sdo
);
    logic [WORD_MAX-1:0] word_q;
    int                  idx;

    // Latch the new sample, or zeros for a skipped or starved slot.
    always_ff @(posedge clk) begin
        if (!rst_n)      word_q <= '0;
        else if (reload) word_q <= take ? in_data : '0;
    end

    // Map the bit position within the slot onto a sample bit index.
    always_comb begin
        idx = -1;
        if (!cfg_right) begin
            if (int'(bit_cnt) < int'(cfg_word_w))
                idx = int'(cfg_word_w) - 1 - int'(bit_cnt);
        end else if (int'(bit_cnt) >= int'(cfg_slot_w) - int'(cfg_word_w)) begin
            idx = int'(cfg_slot_w) - 1 - int'(bit_cnt);
        end
    end

    assign sdo = (idx >= 0 && idx < WORD_MAX) ? word_q[idx[WIW-1:0]] : 1'b0;

endmodule

// File: rtl/tdm_slot_flags.sv
// Per-slot status: underrun for the current slot, last slot of the frame,
// and even-indexed enabled slot. Underrun is latched when a slot loads and
// holds for that slot.
module tdm_slot_flags #(
    parameter int MAX_SLOTS = 8,
    localparam int SIW = $clog2(MAX_SLOTS),
    localparam int CNW = $clog2(MAX_SLOTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reload,
    input  logic                 starve,
    input  logic                 started,
    input  logic [SIW-1:0]       slot_cnt,
    input  logic [CNW-1:0]       cfg_slots,
    input  logic [MAX_SLOTS-1:0] cfg_slot_mask,
    output logic                 underrun,
    output logic                 last_slot,
    output logic                 even_slot
);
    logic under_q;

    // Capture whether the slot being loaded had no sample.
    always_ff @(posedge clk) begin
        if (!rst_n)      under_q <= 1'b0;
        else if (reload) under_q <= starve;
    end

    assign underrun  = under_q;
    assign last_slot = started && (int'(slot_cnt) == int'(cfg_slots) - 1);
    assign even_slot = started && !slot_cnt[0] && cfg_slot_mask[slot_cnt];

endmodule

// File: rtl/tdm_frame_tx.sv
// TDM serial frame transmitter top. Joins the frame timer, the slot
// serializer and the slot flags, and runs the sample handshake. One bit
// moves per bclk_en cycle. Assumes config is stable outside reset.
module tdm_frame_tx #(
    parameter int MAX_SLOTS = 8,
    parameter int SLOT_MAX  = 32,
    parameter int WORD_MAX  = 24,
    localparam int SIW = $clog2(MAX_SLOTS),
    localparam int CNW = $clog2(MAX_SLOTS + 1),
    localparam int BIW = $clog2(SLOT_MAX),
    localparam int SWW = $clog2(SLOT_MAX + 1),
    localparam int WWW = $clog2(WORD_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bclk_en,
    input  logic [CNW-1:0]       cfg_slots,
    input  logic [SWW-1:0]       cfg_slot_w,
    input  logic [WWW-1:0]       cfg_word_w,
    input  logic [MAX_SLOTS-1:0] cfg_slot_mask,
    input  logic                 cfg_fs_word,
    input  logic                 cfg_fs_early,
    input  logic                 cfg_fs_inv,
    input  logic                 cfg_right_align,
    input  logic                 cfg_slave,
    input  logic                 fs_in,
    input  logic [WORD_MAX-1:0]  in_data,
    input  logic                 in_valid,
    output logic                 in_ready,
    output logic                 sdo,
    output logic                 fs_out,
    output logic                 underrun,
    output logic                 last_slot,
    output logic                 even_slot
);
    logic           started, slot_start, resync;
    logic [SIW-1:0] slot_cnt, next_slot;
    logic [BIW-1:0] bit_cnt;
    logic           reload, take, starve;

    assign in_ready = rst_n && bclk_en && slot_start && cfg_slot_mask[next_slot];
    assign take     = in_ready && in_valid;
    assign starve   = in_ready && !in_valid;
    assign reload   = bclk_en && (slot_start || resync);

    tdm_frame_timer #(.MAX_SLOTS(MAX_SLOTS), .SLOT_MAX(SLOT_MAX)) u_timer (
        .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en),
        .cfg_slots(cfg_slots), .cfg_slot_w(cfg_slot_w),
        .cfg_fs_word(cfg_fs_word), .cfg_fs_early(cfg_fs_early),
        .cfg_fs_inv(cfg_fs_inv), .cfg_slave(cfg_slave), .fs_in(fs_in),
        .started(started), .slot_cnt(slot_cnt), .bit_cnt(bit_cnt),
        .next_slot(next_slot), .slot_start(slot_start), .resync(resync),
        .fs_out(fs_out)
    );

    tdm_slot_serializer #(.SLOT_MAX(SLOT_MAX), .WORD_MAX(WORD_MAX)) u_ser (
        .clk(clk), .rst_n(rst_n), .reload(reload), .take(take),
        .in_data(in_data), .cfg_word_w(cfg_word_w), .cfg_slot_w(cfg_slot_w),
        .cfg_right(cfg_right_align), .bit_cnt(bit_cnt), .sdo(sdo)
    );

    tdm_slot_flags #(.MAX_SLOTS(MAX_SLOTS)) u_flags (
        .clk(clk), .rst_n(rst_n), .reload(reload), .starve(starve),
        .started(started), .slot_cnt(slot_cnt), .cfg_slots(cfg_slots),
        .cfg_slot_mask(cfg_slot_mask), .underrun(underrun),
        .last_slot(last_slot), .even_slot(even_slot)
    );

    // R7
    masked_slot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started && !cfg_slot_mask[slot_cnt]) |-> !sdo);

    // R8
    starved_slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> !sdo);

    // R10
    slave_sync_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_slave |-> (fs_out == cfg_fs_inv));

endmodule

// File: tb/tb_tdm_frame_tx.sv
// Self-checking bench: walks a table of framing setups with a bit-level
// frame model, then runs directed reset and idle checks.
module tb_tdm_frame_tx;

    typedef struct packed {
        logic [3:0] slots;
        logic [5:0] sw;
        logic [4:0] ww;
        logic [7:0] mask;
        logic       fsw;
        logic       early;
        logic       inv;
        logic       ralign;
        logic       slave;
        logic [7:0] starve;
        logic [9:0] nt;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{4'd2, 6'd16, 5'd16, 8'h03, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF, 10'd80},  // I2S
        '{4'd2, 6'd16, 5'd12, 8'h03, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 10'd80},  // left-justified
        '{4'd2, 6'd16, 5'd12, 8'h03, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'hFF, 10'd80},  // right-justified
        '{4'd4, 6'd8,  5'd8,  8'h0F, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 10'd80},  // DSP-A
        '{4'd4, 6'd8,  5'd8,  8'h0F, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 10'd80},  // DSP-B
        '{4'd4, 6'd8,  5'd8,  8'h05, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 10'd72},  // masked slots
        '{4'd1, 6'd8,  5'd8,  8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 10'd40},  // one-slot frame
        '{4'd4, 6'd8,  5'd8,  8'h0F, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hFF, 10'd72},  // inverted DSP-B
        '{4'd3, 6'd8,  5'd6,  8'h07, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd2,  10'd72},  // starve last slot
        '{4'd2, 6'd8,  5'd8,  8'h03, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'hFF, 10'd64},  // slave, early
        '{4'd4, 6'd8,  5'd8,  8'h0F, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 10'd80},  // slave, aligned
        '{4'd8, 6'd32, 5'd24, 8'hB3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF, 10'd300}  // wide TDM
    };

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n, bclk_en, in_valid, fs_in;
    logic [23:0] in_data;
    logic [3:0]  cfg_slots;
    logic [5:0]  cfg_slot_w;
    logic [4:0]  cfg_word_w;
    logic [7:0]  cfg_slot_mask;
    logic        cfg_fs_word, cfg_fs_early, cfg_fs_inv, cfg_right_align, cfg_slave;
    logic        in_ready, sdo, fs_out, underrun, last_slot, even_slot;

    tdm_frame_tx dut (
        .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en),
        .cfg_slots(cfg_slots), .cfg_slot_w(cfg_slot_w), .cfg_word_w(cfg_word_w),
        .cfg_slot_mask(cfg_slot_mask), .cfg_fs_word(cfg_fs_word),
        .cfg_fs_early(cfg_fs_early), .cfg_fs_inv(cfg_fs_inv),
        .cfg_right_align(cfg_right_align), .cfg_slave(cfg_slave), .fs_in(fs_in),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .sdo(sdo), .fs_out(fs_out), .underrun(underrun),
        .last_slot(last_slot), .even_slot(even_slot)
    );

    int nvec = 0, nbad = 0;
    bit finished = 0;

    // model state
    bit          m_started, m_prev, m_under, starved;
    int          m_slot, m_bit, consumed, starve_k, k_tick;
    logic [23:0] m_word;

    function automatic logic [23:0] gen(input int k);
        return 24'((k + 1) * 32'h009E3779);
    endfunction

    function automatic logic sync_on(input int fidx);
        int len, flen, rel;
        flen = int'(cfg_slots) * int'(cfg_slot_w);
        len  = cfg_fs_word ? int'(cfg_slot_w) : 1;
        rel  = fidx;
        if (cfg_fs_early) rel = (fidx + 1) % flen;
        return rel < len;
    endfunction

    function automatic logic data_bit(input logic [23:0] w, input int b);
        int sw, ww;
        sw = int'(cfg_slot_w);
        ww = int'(cfg_word_w);
        if (!cfg_right_align) return (b < ww) ? w[ww - 1 - b] : 1'b0;
        return (b >= sw - ww) ? w[sw - 1 - b] : 1'b0;
    endfunction

    task automatic chk(input logic got, input logic exp, input string tag);
        nvec++;
        if (got !== exp) begin
            nbad++;
            $display("FAIL %s: actual %0b expected %0b (t=%0t)", tag, got, exp, $time);
        end
    endtask

    task automatic check_line(input string when);
        logic ef, es;
        ef = (m_started && !cfg_slave && sync_on(m_slot * int'(cfg_slot_w) + m_bit)) ^ cfg_fs_inv;
        es = m_started ? data_bit(m_word, m_bit) : 1'b0;
        if (cfg_slave) chk(fs_out, ef, {"R10 fs_out ", when});
        else           chk(fs_out, ef, {"R3 R4 R5 fs_out ", when});
        if (!cfg_slot_mask[m_slot])  chk(sdo, es, {"R7 sdo masked ", when});
        else if (m_under)            chk(sdo, es, {"R8 sdo starved ", when});
        else                         chk(sdo, es, {"R6 sdo ", when});
    endtask

    task automatic check_flags(input string when);
        chk(underrun, m_under, {"R8 underrun ", when});
        chk(last_slot, m_started && (m_slot == int'(cfg_slots) - 1), {"R9 last_slot ", when});
        chk(even_slot, m_started && (m_slot % 2 == 0) && cfg_slot_mask[m_slot],
            {"R9 even_slot ", when});
    endtask

    // One bit period: tick cycle then idle cycle. Starts and ends at negedge.
    task automatic do_tick();
        int  flen, ns, nb;
        logic act, rs, st;
        flen = int'(cfg_slots) * int'(cfg_slot_w);
        if (cfg_slave) fs_in = sync_on((k_tick + 5) % flen) ^ cfg_fs_inv;
        else           fs_in = 1'b0;
        in_data  = gen(consumed);
        in_valid = !(starve_k == consumed && !starved);
        bclk_en  = 1'b1;
        act = fs_in ^ cfg_fs_inv;
        rs  = cfg_slave && act && !m_prev;
        if (rs) begin
            ns = cfg_fs_early ? int'(cfg_slots) - 1 : 0;
            nb = cfg_fs_early ? int'(cfg_slot_w) - 1 : 0;
        end else if (!m_started) begin
            ns = 0; nb = 0;
        end else if (m_bit == int'(cfg_slot_w) - 1) begin
            nb = 0;
            ns = (m_slot == int'(cfg_slots) - 1) ? 0 : m_slot + 1;
        end else begin
            ns = m_slot; nb = m_bit + 1;
        end
        st = (nb == 0);
        #1;
        chk(in_ready, st && cfg_slot_mask[ns], "R7 in_ready");
        @(posedge clk);
        if (st) begin
            if (cfg_slot_mask[ns]) begin
                if (in_valid) begin m_word = in_data; m_under = 0; consumed++; end
                else begin m_word = '0; m_under = 1; starved = 1; end
            end else begin
                m_word = '0; m_under = 0;
            end
        end else if (rs) begin
            m_word = '0; m_under = 0;
        end
        m_started = 1; m_slot = ns; m_bit = nb; m_prev = act; k_tick++;
        @(negedge clk);
        bclk_en = 1'b0;
        check_line("R1 after tick");
        check_flags("after tick");
        @(posedge clk);
        @(negedge clk);
        check_line("R11 between ticks");
    endtask

    task automatic apply_reset(input vec_t v);
        rst_n = 1'b0;
        cfg_slots = v.slots; cfg_slot_w = v.sw; cfg_word_w = v.ww;
        cfg_slot_mask = v.mask; cfg_fs_word = v.fsw; cfg_fs_early = v.early;
        cfg_fs_inv = v.inv; cfg_right_align = v.ralign; cfg_slave = v.slave;
        starve_k = (v.starve == 8'hFF) ? -1 : int'(v.starve);
        bclk_en = 1'b1; in_valid = 1'b1; fs_in = 1'b0; in_data = gen(0);
        @(posedge clk); @(posedge clk); #1;
        // R2 reset state, bclk_en held high
        chk(sdo, 1'b0, "R2 sdo in reset");
        chk(fs_out, v.inv, "R2 fs_out in reset");
        chk(in_ready, 1'b0, "R2 in_ready in reset");
        chk(underrun, 1'b0, "R2 underrun in reset");
        chk(last_slot, 1'b0, "R2 last_slot in reset");
        chk(even_slot, 1'b0, "R2 even_slot in reset");
        @(negedge clk);
        rst_n = 1'b1; bclk_en = 1'b0;
        m_started = 0; m_prev = 0; m_under = 0; starved = 0;
        m_slot = 0; m_bit = 0; consumed = 0; k_tick = 0; m_word = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nbad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bclk_en = 1'b0; in_valid = 1'b0; fs_in = 1'b0; in_data = '0;
        @(negedge clk);
        for (int v = 0; v < NV; v++) begin
            apply_reset(VECS[v]);
            for (int t = 0; t < int'(VECS[v].nt); t++) do_tick();
        end

        // Directed: no ticks after reset leave the line idle (R1, R2)
        apply_reset(VECS[0]);
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk(sdo, 1'b0, "R1 sdo idle without bclk_en");
        chk(fs_out, 1'b1, "R1 fs_out idle without bclk_en");
        chk(last_slot, 1'b0, "R1 last_slot idle without bclk_en");
        do_tick();
        // R4 R5: I2S framing drives sync low on slot 0 bit 0
        chk(fs_out, 1'b0, "R4 R5 fs_out first bit I2S");
        chk(sdo, gen(0)[15], "R6 first bit MSB");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule